// File: doc/BRIEF.md
# Interrupt Polarity Front-End

This block sits between a group of external interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each pin is first brought into the block's clock domain by a two-flop synchronizer. It then passes through an XOR with its own polarity bit. A set bit turns an active-low level into an active-high one and a falling edge into a rising one. A clear bit passes the line through unchanged. Every pin drives exactly one output, and that output connects to one downstream interrupt input.

Software reaches the block over a small 32-bit register bus with two word registers. The polarity register holds one bit per line, and every implemented bit resets to 1, so all lines start out inverted. The bit-order register resets to 0. When it holds all ones, every access to the polarity register is bit-mirrored, so logical bit n appears at bus bit 31-n. Software should set the bit order before it touches the polarity register. Edge capture, masking, priority and acknowledge all stay in the downstream controller.

Top module: `irqpol_frontend`

## Requirements
- R1: Reset state. After reset the polarity register reads back with all NUM_LINES low bits set (0x0000_003F for the default of 6 lines) and the bit-order register reads 0. While the inputs are low, every output is high.
- R2: With normal bit order, line n's polarity bit sits at bus bit n (mask 1<<n) of the polarity register at word address 0, for both writes and reads.
- R3: A polarity bit of 1 makes the output the inverse of the synchronized input. A bit of 0 makes the output equal to it.
- R4: In normal bit order, polarity bits at positions NUM_LINES and above always read as 0. A write to those positions has no effect on any output or on the read value.
- R5: A change on an input reaches its output after the second rising clock edge following the change (two-flop synchronizer), and no sooner.
- R6: A write to the polarity register takes effect on the outputs right after the rising edge that captures the write. Polarity bits change only through such a write.
- R7: When the bit-order register (word address 1) holds 0xFFFF_FFFF, polarity reads and writes are mirrored: logical bit n is at bus bit 31-n. In this mode bus bits 31-NUM_LINES down to 0 read as 0.
- R8: The bit-order register is always accessed in normal order and reads back the value last written. Any value other than all ones keeps normal bit order.
- R9: Each output depends only on its own input and its own polarity bit.
- R10: bus_rdata is 0 whenever bus_rd is low. Word addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Word address: 0 polarity, 1 bit order |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_rd | input | 1 | Read enable for bus_rdata |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| irq_in | input | NUM_LINES | External interrupt pins |
| irq_out | output | NUM_LINES | Polarity-corrected interrupts to the downstream controller |

## Verification
The collision that matters is a polarity write landing on the same rising edge where a synchronized input transition reaches the XOR stage. In that case both operands of a line's XOR change together. If the two changes cancel, the output must not move, and if they do not cancel, it must show exactly one step. The bench provokes this by toggling pins exactly two edges before it issues a polarity write. A behavioural model with its own two-deep input history compares every output on every clock, so any off-by-one in either path shows as a mismatch in that cycle. The same collision is repeated with mirrored bit order enabled.

// File: rtl/irqpol_pkg.sv
package irqpol_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_POLARITY = 2'd0,
    SEL_BITORDER = 2'd1
  } reg_sel_e;

  function automatic logic [BUS_W-1:0] mirror32(input logic [BUS_W-1:0] v);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < BUS_W; k++) r[k] = v[BUS_W-1-k];
    return r;
  endfunction

endpackage

// File: rtl/irqpol_rstsync.sv
module irqpol_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irqpol_sync.sv
module irqpol_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q, safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= din;
      safe_q <= meta_q;
    end
  end

  assign dout = safe_q;

  // checker support: edges seen since reset, saturating at 3
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (dout == $past(din, 2))); // R5
endmodule

// File: rtl/irqpol_regs.sv
module irqpol_regs
  import irqpol_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  output logic [NUM_LINES-1:0] polarity
);
  localparam int PAD_W = BUS_W - NUM_LINES;

  logic [NUM_LINES-1:0] pol_q, pol_d;
  logic [BUS_W-1:0]     ord_q, ord_d;
  logic                 pol_en, ord_en, mirrored;
  logic [BUS_W-1:0]     wr_logical, pol_wide;

  always_comb begin
    mirrored   = (ord_q == {BUS_W{1'b1}});
    pol_en     = wr && (addr == SEL_POLARITY);
    ord_en     = wr && (addr == SEL_BITORDER);
    wr_logical = mirrored ? mirror32(wdata) : wdata;
    pol_d      = wr_logical[NUM_LINES-1:0];
    ord_d      = wdata;
    pol_wide   = {{PAD_W{1'b0}}, pol_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '1;
      ord_q <= '0;
    end else begin
      if (pol_en) pol_q <= pol_d;
      if (ord_en) ord_q <= ord_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        SEL_POLARITY: rdata = mirrored ? mirror32(pol_wide) : pol_wide;
        SEL_BITORDER: rdata = ord_q;
        default:      rdata = '0;
      endcase
    end
  end

  assign polarity = pol_q;

  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R10
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == SEL_POLARITY) |=> $stable(polarity)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == SEL_POLARITY && ord_q != '1) |-> (rdata[BUS_W-1:NUM_LINES] == '0)); // R4
  AST_MIRROR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == SEL_POLARITY && ord_q == '1) |-> (rdata[PAD_W-1:0] == '0)); // R7
endmodule

// File: rtl/irqpol_frontend.sv
module irqpol_frontend
  import irqpol_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic                 rst_n_int;
  logic [NUM_LINES-1:0] synced, polarity;

  irqpol_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  irqpol_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (irq_in),
    .dout  (synced)
  );

  irqpol_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .polarity (polarity)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign irq_out[i] = synced[i] ^ polarity[i];

    AST_LINE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n_int)
      ($stable(synced[i]) && $stable(polarity[i])) |-> $stable(irq_out[i])); // R9
  end
endmodule

// File: tb/irqpol_frontend_tb_top.sv
`timescale 1ns/1ps
module irqpol_frontend_tb_top;
  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  irq_out;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irqpol_frontend #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // behavioural reference model
  int unsigned m_pol, m_ord;
  int unsigned hist[$];

  function automatic int unsigned flip(input int unsigned v);
    int unsigned r = 0;
    for (int k = 0; k < 32; k++) if (v[k]) r[31-k] = 1'b1;
    return r;
  endfunction

  function automatic int unsigned exp_read(input int a, input bit rd);
    if (!rd) return 0;
    if (a == 0) return (m_ord == 32'hFFFF_FFFF) ? flip(m_pol) : m_pol;
    if (a == 1) return m_ord;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pol = (1 << N) - 1;
      m_ord = 0;
      hist  = '{0, 0};
    end else begin
      if (bus_wr && bus_addr == 2'd0)
        m_pol = ((m_ord == 32'hFFFF_FFFF) ? flip(bus_wdata) : bus_wdata) & ((1 << N) - 1);
      else if (bus_wr && bus_addr == 2'd1)
        m_ord = bus_wdata;
      hist.push_back(int'(irq_in));
      void'(hist.pop_front());
    end
  end

  // per-cycle output comparison, R3 R5 R6 R9
  always @(negedge clk) begin
    if (rst_n) begin
      int unsigned e;
      e = (hist[0] ^ m_pol) & ((1 << N) - 1);
      checks++;
      if (int'(irq_out) != e) begin
        errors++;
        $display("FAIL R5/R3 output: got %h expected %h at %0t", irq_out, e[N-1:0], $time);
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input logic [1:0] a, input bit rd, input string req);
    int unsigned e;
    @(negedge clk);
    bus_addr = a; bus_rd = rd;
    #1;
    e = exp_read(a, rd);
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, bus_rdata, e);
    end
    bus_rd = 1'b0;
  endtask

  task automatic value_check(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    read_check(2'd0, 1'b1, "R1");
    read_check(2'd1, 1'b1, "R1");
    #1 value_check(32'(irq_out), 32'h3F, "R1 outputs inverted at reset");

    // R4 writes above implemented lines are dropped
    bus_write(2'd0, 32'hFFFF_FF05);
    read_check(2'd0, 1'b1, "R4");
    #1 value_check(32'(irq_out), 32'h05, "R4 output unaffected by upper bits");

    // R2 / R3 single-bit masks
    for (int n = 0; n < N; n++) begin
      bus_write(2'd0, 32'h1 << n);
      read_check(2'd0, 1'b1, "R2");
      #1 value_check(32'(irq_out), 32'h1 << n, "R3 single inverted line");
    end

    // R5 / R9 input patterns with mixed polarity
    bus_write(2'd0, 32'h15);
    for (int p = 0; p < 40; p++) begin
      @(negedge clk);
      irq_in = N'((p * 37 + 11) ^ (p >> 1));
    end
    irq_in = '0;
    idle(3);
    @(negedge clk) irq_in = 6'b000100;
    @(negedge clk);
    #1 value_check(32'(irq_out), 32'h15, "R5 no change after one edge");
    @(negedge clk);
    #1 value_check(32'(irq_out), 32'h11, "R5 change after two edges");

    // R10 idle read, unmapped addresses
    read_check(2'd0, 1'b0, "R10");
    bus_write(2'd3, 32'h0000_0000);
    bus_write(2'd2, 32'hFFFF_FFFF);
    read_check(2'd3, 1'b1, "R10");
    read_check(2'd2, 1'b1, "R10");
    read_check(2'd0, 1'b1, "R10 polarity unchanged");
    read_check(2'd1, 1'b1, "R10 order unchanged");

    // R8 non-all-ones order value keeps normal order
    bus_write(2'd1, 32'h7FFF_FFFF);
    read_check(2'd1, 1'b1, "R8");
    bus_write(2'd0, 32'h0000_0003);
    read_check(2'd0, 1'b1, "R8 normal order kept");

    // R7 mirrored mode
    bus_write(2'd1, 32'hFFFF_FFFF);
    read_check(2'd1, 1'b1, "R8 order reads normal");
    read_check(2'd0, 1'b1, "R7");
    bus_write(2'd0, 32'h8000_0000);
    read_check(2'd0, 1'b1, "R7");
    #1 value_check(32'(irq_out), 32'h01 ^ 32'(irq_in), "R7 logical line 0 inverted");
    bus_write(2'd0, 32'h0000_00FF);
    read_check(2'd0, 1'b1, "R7 low bus bits dropped");

    // collision: input edge reaches XOR on the write edge (R6)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) irq_in = ~irq_in;
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = flip(32'(c * 9 + 5)); bus_wr = 1'b1;
      @(negedge clk) bus_wr = 1'b0;
      idle(2);
    end
    bus_write(2'd1, 32'h0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) irq_in = N'(c * 13 + 1);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 32'(c * 7 + 2); bus_wr = 1'b1;
      @(negedge clk) bus_wr = 1'b0;
      read_check(2'd0, 1'b1, "R6");
    end
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule